// File: doc/BRIEF.md
# Timebase Trim Unit

This unit sits in a seconds divider chain at the stage that divides by 256 and nudges the count by a programmable amount. The upstream oscillator stage delivers a stream of tick tokens. Each token stands for one half-period of the 128 Hz stage, which is 128 oscillator cycles. The downstream stages consume the corrected token stream and count it into seconds. They also feed back two plain markers: one at the start of each second and one at the start of each minute.

A private counter walks through a 64-minute calibration cycle. At the mark that opens minute 0, the unit latches a 5-bit magnitude N and a sign. In each of the first 2N minutes of the cycle, the first second is edited. A negative setting swallows one token, which costs 128 oscillator cycles and slows the clock. A positive setting injects two extra tokens, which adds 256 cycles and speeds the clock. One step therefore moves the count by -256 or +512 oscillator cycles per cycle, about -2.03 or +4.07 ppm. The last two minutes of the cycle are never edited.

Both token interfaces use valid/ready. The unit never stores a token. In pass-through the downstream ready is fed straight back upstream. While extra tokens are being injected, the upstream side is stalled, and the injected tokens wait on the downstream ready. While a token is being swallowed, the upstream side is accepted with no output. Any frequency-test tap must be taken upstream of this unit, so the calibration setting does not move it.

Top module: `cal_trim_unit`

## Requirements
- R1: With a latched magnitude of 0, every accepted input token appears at the output, for either sign.
- R2: With sign 0 and magnitude N > 0, in each affected minute exactly one accepted input token yields no output token. The net over one cycle is -2N tokens.
- R3: With sign 1 and magnitude N > 0, in each affected minute two tokens are emitted that have no input token behind them. The net over one cycle is +4N tokens.
- R4: The affected minutes are minute indices 0 to 2N-1 of the cycle. Index 0 is the first minute mark after reset. Minutes 62 and 63 are never affected.
- R5: Magnitude and sign are sampled only at the minute mark that opens minute 0. A change at any other time takes effect only from the next cycle.
- R6: An edit starts no earlier than the cycle after the minute mark. A token that is accepted in the same cycle as the minute mark passes through unchanged.
- R7: A second mark without a minute mark closes the edit window. A swallow still pending at that point is dropped.
- R8: While tokens are being injected, tick_out_valid is 1 and tick_in_ready is 0, and an injected token stays valid until tick_out_ready takes it. While a swallow is pending, tick_in_ready is 1 and tick_out_valid is 0. Otherwise tick_out_valid follows tick_in_valid and tick_in_ready follows tick_out_ready.
- R9: After reset, the unit is in pass-through and the minute index is 0.
- R10: The calibration cycle is 64 minute marks long and then repeats, latching a new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in_valid | input | 1 | Upstream token present |
| tick_in_ready | output | 1 | Upstream token accepted |
| tick_out_valid | output | 1 | Corrected token present |
| tick_out_ready | input | 1 | Downstream takes the token |
| min_mark | input | 1 | One-cycle pulse at the start of a minute |
| sec_mark | input | 1 | One-cycle pulse at the start of a second |
| cal_mag | input | 5 | Trim magnitude N |
| cal_sign | input | 1 | 1 speeds the clock, 0 slows it |

## Verification
Two events can land in the same cycle. The first is a minute mark that coincides with a token handshake; that token must pass through untouched, and the edit lands on later tokens. The second is the minute-0 mark itself, which both latches the new setting and arms the edit for that minute. Half of the sweep configurations present the first token of every minute in the mark cycle. The mid-cycle change runs alter the setting just after a minute-0 mark. Each run is judged by the net token count over a whole 64-minute cycle, which must match the arithmetic expectation.

// File: rtl/cal_trim_pkg.sv
package cal_trim_pkg;
  typedef enum logic [1:0] {
    EM_PASS  = 2'd0,
    EM_SPLIT = 2'd1,
    EM_BLANK = 2'd2
  } edit_mode_e;
endpackage

// File: rtl/cal_minute_seq.sv
module cal_minute_seq #(
  parameter int CYCLE_MIN = 64,
  parameter int MAG_W     = 5,
  parameter int FREE_MIN  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         min_mark,
  input  logic [MAG_W-1:0]             cal_mag,
  input  logic                         cal_sign,
  output logic [$clog2(CYCLE_MIN)-1:0] cur_min,
  output logic [MAG_W-1:0]             act_mag,
  output logic                         act_sign,
  output logic                         arm_pos,
  output logic                         arm_neg
);
  localparam int MIN_W    = $clog2(CYCLE_MIN);
  localparam int CMP_W    = (MIN_W > MAG_W + 1) ? MIN_W : MAG_W + 1;
  localparam int EDIT_LIM = CYCLE_MIN - FREE_MIN;

  logic             cycle_start;
  logic [MAG_W-1:0] nxt_mag;
  logic             nxt_sign;
  logic [CMP_W-1:0] span;
  logic [CMP_W-1:0] pos_x;
  logic             hit;

  // the setting is latched only as minute 0 opens
  assign cycle_start = (cur_min == '0);
  assign nxt_mag     = cycle_start ? cal_mag  : act_mag;
  assign nxt_sign    = cycle_start ? cal_sign : act_sign;
  assign span        = CMP_W'(nxt_mag) << 1;
  assign pos_x       = CMP_W'(cur_min);
  assign hit         = (pos_x < span) && (pos_x < CMP_W'(EDIT_LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_min  <= '0;
      act_mag  <= '0;
      act_sign <= 1'b0;
      arm_pos  <= 1'b0;
      arm_neg  <= 1'b0;
    end else begin
      arm_pos <= 1'b0;
      arm_neg <= 1'b0;
      if (min_mark) begin
        cur_min  <= (cur_min == MIN_W'(CYCLE_MIN - 1)) ? '0 : cur_min + MIN_W'(1);
        act_mag  <= nxt_mag;
        act_sign <= nxt_sign;
        arm_pos  <= hit && nxt_sign;
        arm_neg  <= hit && !nxt_sign;
      end
    end
  end
endmodule

// File: rtl/cal_tick_editor.sv
module cal_tick_editor
  import cal_trim_pkg::*;
#(
  parameter int SPLIT_N = 2,
  parameter int BLANK_N = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_pos,
  input  logic       arm_neg,
  input  logic       win_close,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       out_valid,
  input  logic       out_ready,
  output edit_mode_e mode
);
  localparam int SW = $clog2(SPLIT_N + 1);
  localparam int BW = $clog2(BLANK_N + 1);

  logic [SW-1:0] split_left;
  logic [BW-1:0] blank_left;

  always_comb begin
    if (split_left != '0)      mode = EM_SPLIT;
    else if (blank_left != '0) mode = EM_BLANK;
    else                       mode = EM_PASS;
  end

  always_comb begin
    unique case (mode)
      EM_SPLIT: begin out_valid = 1'b1;     in_ready = 1'b0;      end
      EM_BLANK: begin out_valid = 1'b0;     in_ready = 1'b1;      end
      default:  begin out_valid = in_valid; in_ready = out_ready; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_left <= '0;
      blank_left <= '0;
    end else if (arm_pos) begin
      split_left <= SW'(SPLIT_N);
      blank_left <= '0;
    end else if (arm_neg) begin
      split_left <= '0;
      blank_left <= BW'(BLANK_N);
    end else if (win_close) begin
      split_left <= '0;
      blank_left <= '0;
    end else if (mode == EM_SPLIT) begin
      if (out_ready) split_left <= split_left - SW'(1);
    end else if (mode == EM_BLANK) begin
      if (in_valid) blank_left <= blank_left - BW'(1);
    end
  end
endmodule

// File: rtl/cal_trim_unit.sv
module cal_trim_unit #(
  parameter int CYCLE_MIN = 64,
  parameter int MAG_W     = 5,
  parameter int FREE_MIN  = 2,
  parameter int SPLIT_N   = 2,
  parameter int BLANK_N   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in_valid,
  output logic             tick_in_ready,
  output logic             tick_out_valid,
  input  logic             tick_out_ready,
  input  logic             min_mark,
  input  logic             sec_mark,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_sign
);
  import cal_trim_pkg::*;
  localparam int MIN_W = $clog2(CYCLE_MIN);

  logic [MIN_W-1:0] cur_min;
  logic [MAG_W-1:0] act_mag;
  logic             act_sign;
  logic             arm_pos;
  logic             arm_neg;
  logic             win_close;
  edit_mode_e       mode;

  // a second mark that is also a minute mark opens a window, it does not close one
  assign win_close = sec_mark && !min_mark;

  cal_minute_seq #(
    .CYCLE_MIN(CYCLE_MIN), .MAG_W(MAG_W), .FREE_MIN(FREE_MIN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .min_mark(min_mark),
    .cal_mag(cal_mag), .cal_sign(cal_sign),
    .cur_min(cur_min), .act_mag(act_mag), .act_sign(act_sign),
    .arm_pos(arm_pos), .arm_neg(arm_neg)
  );

  cal_tick_editor #(
    .SPLIT_N(SPLIT_N), .BLANK_N(BLANK_N)
  ) u_edit (
    .clk(clk), .rst_n(rst_n), .arm_pos(arm_pos), .arm_neg(arm_neg),
    .win_close(win_close), .in_valid(tick_in_valid), .in_ready(tick_in_ready),
    .out_valid(tick_out_valid), .out_ready(tick_out_ready), .mode(mode)
  );
endmodule

// File: rtl/cal_trim_unit_chk.sv
module cal_trim_unit_chk
  import cal_trim_pkg::*;
#(
  parameter int CYCLE_MIN = 64,
  parameter int MAG_W     = 5,
  parameter int FREE_MIN  = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         min_mark,
  input logic                         sec_mark,
  input logic                         out_ready,
  input logic                         out_valid,
  input logic [$clog2(CYCLE_MIN)-1:0] cur_min,
  input logic [MAG_W-1:0]             act_mag,
  input logic                         act_sign,
  input logic                         arm_pos,
  input logic                         arm_neg,
  input edit_mode_e                   mode
);
  localparam int MIN_W = $clog2(CYCLE_MIN);

  // R2 / R3: never both edit directions at once
  p_arm_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arm_pos, arm_neg}));

  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (min_mark && cur_min == MIN_W'(CYCLE_MIN - 1)) |=> (cur_min == '0));

  p_late_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_pos || arm_neg) |-> ($past(cur_min) < MIN_W'(CYCLE_MIN - FREE_MIN)));

  p_mag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (min_mark && cur_min != '0) |=> ($stable(act_mag) && $stable(act_sign)));

  p_zero_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mag == '0) |-> (!arm_pos && !arm_neg));

  p_split_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EM_SPLIT && !out_ready && !(sec_mark && !min_mark) && !arm_neg) |=> out_valid);
endmodule

bind cal_trim_unit cal_trim_unit_chk #(
  .CYCLE_MIN(CYCLE_MIN), .MAG_W(MAG_W), .FREE_MIN(FREE_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .min_mark(min_mark), .sec_mark(sec_mark),
  .out_ready(tick_out_ready), .out_valid(tick_out_valid),
  .cur_min(cur_min), .act_mag(act_mag), .act_sign(act_sign),
  .arm_pos(arm_pos), .arm_neg(arm_neg), .mode(mode)
);

// File: tb/cal_trim_unit_bench.sv
module cal_trim_unit_bench;
  localparam int TPS = 3;   // tokens per second (accelerated)
  localparam int SPM = 2;   // seconds per minute (accelerated)
  localparam int CYC = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready;
  logic       min_mark = 1'b0;
  logic       sec_mark = 1'b0;
  logic [4:0] cal_mag = '0;
  logic       cal_sign = 1'b0;
  logic       hold_ready = 1'b0;
  logic       stall_en = 1'b0;
  logic [1:0] stall_ph = '0;

  int checks = 0;
  int errors = 0;
  int out_cnt = 0;
  int in_cnt = 0;

  always #5 clk = ~clk;

  assign out_ready = !hold_ready && (!stall_en || stall_ph != 2'd0);

  cal_trim_unit u_cal_trim_unit (
    .clk(clk), .rst_n(rst_n),
    .tick_in_valid(in_valid), .tick_in_ready(in_ready),
    .tick_out_valid(out_valid), .tick_out_ready(out_ready),
    .min_mark(min_mark), .sec_mark(sec_mark),
    .cal_mag(cal_mag), .cal_sign(cal_sign)
  );

  always @(posedge clk) begin
    #1 stall_ph = (stall_ph == 2'd2) ? 2'd0 : stall_ph + 2'd1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) out_cnt++;
      if (in_valid && in_ready) in_cnt++;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send_tick();
    bit acc;
    in_valid = 1'b1;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
      step();
    end
    in_valid = 1'b0;
  endtask

  task automatic do_minute(input bit coinc, input bit skip);
    for (int s = 0; s < SPM; s++) begin
      min_mark = (s == 0);
      sec_mark = 1'b1;
      in_valid = coinc && (s == 0);
      step();
      min_mark = 1'b0;
      sec_mark = 1'b0;
      in_valid = 1'b0;
      if (skip && s == 0) begin
        step();
        step();
      end else begin
        for (int t = ((coinc && s == 0) ? 1 : 0); t < TPS; t++) send_tick();
      end
    end
  endtask

  task automatic run_cycle(input int mag, input bit sign, input bit coinc, input bit stall,
                           input bit skip, input bit chg, input string tag);
    int delta;
    cal_mag  = mag[4:0];
    cal_sign = sign;
    stall_en = stall;
    out_cnt  = 0;
    in_cnt   = 0;
    for (int m = 0; m < CYC; m++) begin
      do_minute(coinc, skip);
      if (m == 0 && chg) begin
        cal_mag  = ~cal_mag;
        cal_sign = ~cal_sign;
      end
    end
    stall_en = 1'b0;
    repeat (4) step();
    if (skip || mag == 0) delta = 0;
    else if (sign) delta = 4 * mag;
    else delta = -2 * mag;
    check(out_cnt == in_cnt + delta, tag, out_cnt, in_cnt + delta);
  endtask

  task automatic directed_cycle(input bit sign);
    cal_mag  = 5'd1;
    cal_sign = sign;
    out_cnt  = 0;
    in_cnt   = 0;
    min_mark = 1'b1;
    sec_mark = 1'b1;
    step();
    min_mark = 1'b0;
    sec_mark = 1'b0;
    hold_ready = 1'b1;
    in_valid = !sign;
    step();
    @(negedge clk);
    if (sign) begin
      check(out_valid == 1'b1 && in_ready == 1'b0, "R8 inject drives out, stalls in",
            {out_valid, in_ready}, 2);
      step();
      @(negedge clk);
      check(out_valid == 1'b1, "R8 injected token held under back-pressure", out_valid, 1);
      step();
      hold_ready = 1'b0;
      for (int t = 0; t < TPS; t++) send_tick();
    end else begin
      check(out_valid == 1'b0 && in_ready == 1'b1, "R8 swallow accepts, drives nothing",
            {out_valid, in_ready}, 1);
      step();
      in_valid = 1'b0;
      hold_ready = 1'b0;
      for (int t = 1; t < TPS; t++) send_tick();
    end
    for (int s = 1; s < SPM; s++) begin
      sec_mark = 1'b1;
      step();
      sec_mark = 1'b0;
      for (int t = 0; t < TPS; t++) send_tick();
    end
    for (int m = 1; m < CYC; m++) do_minute(1'b0, 1'b0);
    repeat (4) step();
    check(out_cnt == in_cnt + (sign ? 4 : -2), sign ? "R3 directed net" : "R2 directed net",
          out_cnt, in_cnt + (sign ? 4 : -2));
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9 reset pass-through",
          {out_valid, in_ready}, 1);

    // full sweep: every magnitude, both signs; odd magnitudes also coincide the
    // first token with the minute mark, magnitude 2 mod 4 adds back-pressure
    for (int sg = 0; sg < 2; sg++) begin
      for (int mg = 0; mg < 32; mg++) begin
        bit co;
        bit st;
        string tag;
        co = (mg % 2) == 1;
        st = (mg % 4) == 2;
        if (mg == 0) tag = "R1 zero magnitude";
        else if (sg == 1) tag = $sformatf("R3/R4/R10 mag %0d positive%s", mg, co ? " R6" : "");
        else tag = $sformatf("R2/R4/R10 mag %0d negative%s", mg, co ? " R6" : "");
        run_cycle(mg, sg[0], co, st, 1'b0, 1'b0, tag);
      end
    end

    run_cycle(5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5 change after cycle start, positive");
    run_cycle(9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 change after cycle start, negative");
    run_cycle(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 setting after change window");
    run_cycle(3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7 swallow dropped at second mark");
    run_cycle(2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 recovery after dropped window");

    directed_cycle(1'b1);
    directed_cycle(1'b0);

    summary();
    $finish;
  end
endmodule